// File: doc/BRIEF.md
# Pointer-Addressed I2C Memory Slave

This block is an I2C slave that opens a 16-bit internal memory space to a bus master. Each transfer begins by loading a two-byte pointer; any bytes after it in the same write sequence are stored at that pointer. After every data byte, the pointer advances by one.

To read, the master sends a write sequence that carries only the two pointer bytes. It then issues a repeated START with the read bit set and clocks out bytes taken from consecutive locations. The block samples SCL and SDA with its own faster system clock. It drives SDA only by pulling it low through an output-enable. It gives a simple single-cycle memory port to whatever storage sits behind it.

Top module: `i2c_ptr_slave`

## Requirements
- R1: While reset is asserted and directly after it is released, `sda_oe`, `mem_we` and `mem_re` are all 0.
- R2: The slave address is 7'h5D, so the write address byte is 8'hBA. The slave acknowledges it by driving SDA low during the ninth clock.
- R3: A byte with any other 7-bit address is not acknowledged. Bytes that follow it on the bus get no acknowledge and cause no memory access until the next START or STOP.
- R4: In a write sequence, the first byte after the address is the pointer high byte and the second is the pointer low byte. Every later byte is acknowledged and written as one `mem_we` pulse, with `mem_addr` equal to the pointer and `mem_wdata` equal to the byte. Bytes are received MSB first.
- R5: The pointer increases by one after every data byte, whether written or read. It wraps from 16'hFFFF to 16'h0000.
- R6: A repeated START with address byte 8'hBB is acknowledged. The slave then sends bytes MSB first from successive pointer locations, and each byte is fetched by one `mem_re` pulse. Read data is taken on the cycle after `mem_re`.
- R7: When the master does not acknowledge a read byte (SDA high in the ninth clock), the slave releases SDA and issues no further `mem_re` until a new sequence.
- R8: A START seen before a byte is complete drops that byte: it is not written. The slave then expects a new address byte.
- R9: SCL and SDA each pass through a two-flop synchroniser. SCL runs up to 1 MHz with a 125 MHz system clock. `sda_oe` changes only while SCL is low.
- R10: `mem_we` and `mem_re` are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| mem_addr | output | 16 | Current pointer, used as memory address |
| mem_wdata | output | 8 | Byte to be written |
| mem_we | output | 1 | Write strobe, one cycle |
| mem_re | output | 1 | Read strobe, one cycle |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |

## Verification
The bench sends writes that run across 16'hFFFF and reads that start there. A pointer that fails to wrap, or that grabs the low byte first, leads to writes or fetches at the wrong address. It sends a foreign address followed by more bytes. A slave that goes on decoding after such an address would acknowledge those bytes or write memory. A START is cut into the middle of a data byte; a design that does not resynchronise writes a corrupted byte or misreads the next address. Reads end with a master NACK, where a slave that keeps streaming would issue an extra fetch or hold SDA low.

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h5D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  input  logic [7:0]  mem_rdata
);
  localparam logic [3:0] BYTE_BITS = 4'd8;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_PH, S_PL, S_WD, S_RLD, S_RD, S_RACK} st_t;

  st_t         st;
  logic [2:0]  scl_q, sda_q;
  logic [7:0]  sh;
  logic [3:0]  bitcnt;
  logic [15:0] ptr;
  logic        ack_drv, rw, inc, re_q;

  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire scl_high = scl_q[1] & scl_q[2];
  wire start_c  = scl_high & ~sda_q[1] & sda_q[2];
  wire stop_c   = scl_high & sda_q[1] & ~sda_q[2];
  wire rx_st    = (st == S_DEV) || (st == S_PH) || (st == S_PL) || (st == S_WD);

  assign mem_addr = ptr;
  assign sda_oe   = ack_drv | ((st == S_RD) & ~sh[7]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q     <= 3'b111;
      sda_q     <= 3'b111;
      st        <= S_IDLE;
      sh        <= 8'h00;
      bitcnt    <= 4'd0;
      ptr       <= 16'h0000;
      ack_drv   <= 1'b0;
      rw        <= 1'b0;
      inc       <= 1'b0;
      re_q      <= 1'b0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_wdata <= 8'h00;
    end else begin
      scl_q  <= {scl_q[1:0], scl_i};
      sda_q  <= {sda_q[1:0], sda_i};
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      re_q   <= mem_re;
      inc    <= 1'b0;
      if (inc) ptr <= ptr + 16'd1;

      if (start_c) begin
        st      <= S_DEV;
        bitcnt  <= 4'd0;
        ack_drv <= 1'b0;
      end else if (stop_c) begin
        st      <= S_IDLE;
        ack_drv <= 1'b0;
      end else if (rx_st) begin
        if (scl_rise && !ack_drv && bitcnt != BYTE_BITS) begin
          sh     <= {sh[6:0], sda_q[1]};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && ack_drv) begin
          ack_drv <= 1'b0;
          bitcnt  <= 4'd0;
          case (st)
            S_DEV: if (rw) begin
                     st     <= S_RLD;
                     mem_re <= 1'b1;
                   end else st <= S_PH;
            S_PH:    st <= S_PL;
            S_PL:    st <= S_WD;
            default: st <= S_WD;
          endcase
        end else if (scl_fall && bitcnt == BYTE_BITS) begin
          if (st == S_DEV) begin
            if (sh[7:1] == DEV_ADDR) begin
              ack_drv <= 1'b1;
              rw      <= sh[0];
            end else st <= S_IDLE;
          end else begin
            ack_drv <= 1'b1;
            if (st == S_PH)      ptr[15:8] <= sh;
            else if (st == S_PL) ptr[7:0]  <= sh;
            else begin
              mem_we    <= 1'b1;
              mem_wdata <= sh;
              inc       <= 1'b1;
            end
          end
        end
      end else begin
        case (st)
          S_RLD: if (re_q) begin
                   sh     <= mem_rdata;
                   bitcnt <= 4'd0;
                   st     <= S_RD;
                 end
          S_RD: if (scl_rise) bitcnt <= bitcnt + 4'd1;
                else if (scl_fall) begin
                  if (bitcnt == BYTE_BITS) begin
                    st  <= S_RACK;
                    inc <= 1'b1;
                  end else sh <= {sh[6:0], 1'b1};
                end
          S_RACK: if (scl_rise && sda_q[1]) st <= S_IDLE;
                  else if (scl_fall) begin
                    st     <= S_RLD;
                    mem_re <= 1'b1;
                  end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_ptr_slave_chk.sv
module i2c_ptr_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_oe,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] mem_addr
);
  a_r10_we_re_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  a_r10_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  a_r10_re_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re);
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_addr == $past(mem_addr) + 16'd1));
  a_r9_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind i2c_ptr_slave i2c_ptr_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr)
);

// File: tb/i2c_ptr_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_ptr_slave_tb_top;
  localparam int Q = 31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, mem_we, mem_re;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] mm [int];
  logic [23:0] wq [$];
  logic [15:0] rq [$];

  always #4 clk = ~clk;

  i2c_ptr_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_we) mm[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= mm.exists(int'(mem_addr)) ? mm[int'(mem_addr)] : 8'h00;
  end

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (wq.size() == 0) chk(1'b0, "R3 unexpected write", {8'h0, mem_addr, mem_wdata}, 0);
      else begin
        logic [23:0] e;
        e = wq.pop_front();
        chk({mem_addr, mem_wdata} == e, "R4 write addr/data", {8'h0, mem_addr, mem_wdata}, {8'h0, e});
      end
    end
    if (rst_n && mem_re) begin
      if (rq.size() == 0) chk(1'b0, "R7 unexpected read fetch", {16'h0, mem_addr}, 0);
      else begin
        logic [15:0] e;
        e = rq.pop_front();
        chk(mem_addr == e, "R6 read fetch addr", {16'h0, mem_addr}, {16'h0, e});
      end
    end
  end

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start;
    sda_m = 1'b1; scl = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask
  task automatic i2c_rstart;
    sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask
  task automatic i2c_stop;
    sda_m = 1'b0; w(Q); scl = 1'b1; w(Q); sda_m = 1'b1; w(2*Q);
  endtask
  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
    end
  endtask
  task automatic wr_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); ack = !sda_bus; w(Q); scl = 1'b0; w(Q);
  endtask
  task automatic rd_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl = 1'b1; w(Q); b[i] = sda_bus; w(Q); scl = 1'b0; w(Q);
    end
    sda_m = !mack; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q); sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    bit a;
    i2c_start;
    wr_byte(8'hBA, a); chk(a, "R2 address ack", a, 1);
    wr_byte(p[15:8], a); chk(a, "R4 pointer high ack", a, 1);
    wr_byte(p[7:0], a); chk(a, "R4 pointer low ack", a, 1);
  endtask

  task automatic write_seq(input logic [15:0] p, input logic [7:0] d [$]);
    bit a;
    set_ptr(p);
    foreach (d[k]) begin
      wq.push_back({p + 16'(k), d[k]});
      wr_byte(d[k], a); chk(a, "R4 data ack", a, 1);
    end
    i2c_stop;
  endtask

  task automatic read_seq(input logic [15:0] p, input logic [7:0] exp [$]);
    bit a;
    logic [7:0] b;
    set_ptr(p);
    i2c_rstart;
    rq.push_back(p);
    wr_byte(8'hBB, a); chk(a, "R6 read address ack", a, 1);
    foreach (exp[k]) begin
      if (k != exp.size() - 1) rq.push_back(p + 16'(k + 1));
      rd_byte(k != exp.size() - 1, b);
      chk(b == exp[k], "R6 read byte MSB first (R5 step, R9 1 MHz)", b, exp[k]);
    end
    w(4);
    chk(!sda_oe, "R7 SDA released after NACK", sda_oe, 0);
    i2c_stop;
    w(40);
    chk(rq.size() == 0, "R7 no fetch after NACK", rq.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a;
    w(5);
    chk(!sda_oe && !mem_we && !mem_re, "R1 outputs idle in reset", {sda_oe, mem_we, mem_re}, 0);
    rst_n = 1'b1;
    w(3);
    chk(!sda_oe && !mem_we && !mem_re, "R1 outputs idle after reset", {sda_oe, mem_we, mem_re}, 0);

    write_seq(16'h1234, '{8'hA5, 8'h3C, 8'hF0});
    write_seq(16'hFFFF, '{8'h11, 8'h22});

    i2c_start;
    wr_byte(8'h80, a); chk(!a, "R3 foreign address not acked", a, 0);
    wr_byte(8'h55, a); chk(!a, "R3 following byte ignored", a, 0);
    i2c_stop;
    w(20);
    chk(wq.size() == 0, "R3 no write from foreign address", wq.size(), 0);

    read_seq(16'h1234, '{8'hA5, 8'h3C, 8'hF0});
    read_seq(16'hFFFF, '{8'h11, 8'h22});

    set_ptr(16'h0040);
    send_bits(8'hFF, 4);
    i2c_rstart;
    wr_byte(8'hBA, a); chk(a, "R8 address ack after abort", a, 1);
    wr_byte(8'h00, a);
    wr_byte(8'h50, a);
    wq.push_back({16'h0050, 8'h77});
    wr_byte(8'h77, a); chk(a, "R8 data ack after abort", a, 1);
    i2c_stop;
    read_seq(16'h0040, '{8'h00});
    read_seq(16'h0050, '{8'h77});

    chk(wq.size() == 0, "R4 all expected writes seen", wq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule